// File: doc/BRIEF.md
# Versatile Interface Adapter Core

This block is a memory-mapped peripheral for an 8-bit processor bus. A 4-bit register select, a chip select and a write strobe pick one of sixteen registers in each bus cycle. Through these registers software controls two 8-bit bidirectional ports, two 16-bit down-counting timers and two edge-sensitive interrupt inputs. Every event source has a flag. A flag that is also enabled raises the interrupt output.

Each port has a direction register and an output latch. The block drives the pin value and the output-enable mask as separate outputs, so the surrounding pad logic or a bench can resolve the pins. Timer 1 runs either one-shot or free-running, and it can toggle the top bit of port B on every underflow. Timer 2 is one-shot only. Interrupt flags clear when software writes ones to the flag register. Some port and timer accesses also clear flags as a side effect.

A bus access takes effect on the rising clock edge while `cs` is high. Read data is combinational from the current state. Read side effects apply at the same edge that ends the access.

Top module: `viaCore`

## Requirements
- R1: After reset the port latches, direction registers, flag register and enable register read 0, except that the enable register reads 0x80. `irq` is low, all port outputs and output enables are 0, and no timer flag appears while no timer has been started.
- R2: Offset 0 is the port B data register, 1 is the port A data register, 2 is the port B direction register and 3 is the port A direction register. A direction bit of 1 means output. A data-register read returns the latch bit for output bits and the input pin for input bits.
- R3: A write to a data register only updates its latch. The port output equals latch AND direction, and the output enable equals the direction register.
- R4: Offset 14 is the enable register. A write with bit 7 = 1 sets the enables whose bits 6..0 are 1. A write with bit 7 = 0 clears them. A read returns bit 7 as 1 above the seven enables.
- R5: Offset 13 is the flag register, with bit 1 for CA1, bit 4 for CB1, bit 5 for timer 2 and bit 6 for timer 1. Bits 0, 2 and 3 read 0. Writing it clears every flag whose written bit is 1. Read bit 7 is 1 exactly when an enabled flag is pending.
- R6: `irq` is high exactly when some flag is set whose enable is also set.
- R7: Timer 1 works as follows. Offsets 4 and 6 write the low latch and offset 7 writes the high latch. A write to offset 5 sets the high latch, loads the counter with {high, low latch}, starts the counter and clears the timer 1 flag. The counter then decreases by one per clock, and the flag sets N+1 clocks after a load of N. Reads of 4 and 5 return the counter bytes, and reads of 6 and 7 return the latches.
- R8: ACR (offset 11) bit 6 = 0 makes timer 1 one-shot, which flags once per start. Bit 6 = 1 makes it free-running, reloading from the latches at each underflow, so it flags every N+1 clocks.
- R9: With ACR bit 7 = 1, port B bit 7 is always enabled as an output and driven by a toggle. The toggle is low after a timer 1 start and inverts on every timer 1 flag event.
- R10: Offset 8 writes the timer 2 low latch. A write to offset 9 loads {data, low latch}, starts the counter and clears the timer 2 flag. The flag sets N+1 clocks later and is raised only once per start.
- R11: The following accesses also clear flags. A read of offset 4 clears the timer 1 flag. A read or write of offset 8 clears the timer 2 flag. An access to offset 1 clears the CA1 flag and an access to offset 0 clears the CB1 flag. Accesses to offsets 5, 9 and 15 leave flags untouched, and offset 15 is otherwise port A.
- R12: PCR (offset 12) bit 0 selects the active CA1 edge and bit 4 the active CB1 edge, with 1 meaning rising and 0 meaning falling. Only a matching edge sets the flag.
- R13: Offset 10 reads 0 and ignores writes. ACR and PCR read back the whole written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Selects the block for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| regSel | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected offset |
| portAIn | input | 8 | Port A pin values |
| portBIn | input | 8 | Port B pin values |
| portAOut | output | 8 | Port A driven values |
| portAOe | output | 8 | Port A output enables |
| portBOut | output | 8 | Port B driven values |
| portBOe | output | 8 | Port B output enables |
| ca1 | input | 1 | Edge interrupt input A |
| cb1 | input | 1 | Edge interrupt input B |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default 8-bit data width, which gives 16-bit timers. At that width a timer load of a few counts reaches an underflow within tens of cycles, so the bench can check the exact flag cycle, the one-shot and free-running periods and the port B bit 7 toggle on single clock edges. A high-byte load of 0xFF parks a timer far beyond the end of the run. Random direction, latch, pin and enable patterns exercise every bit position of the 8-bit ports and the seven enables.

// File: rtl/viaPkg.sv
package viaPkg;
  localparam int FLAG_W = 7;

  localparam logic [3:0] OFS_ORB   = 4'd0;
  localparam logic [3:0] OFS_ORA   = 4'd1;
  localparam logic [3:0] OFS_DDRB  = 4'd2;
  localparam logic [3:0] OFS_DDRA  = 4'd3;
  localparam logic [3:0] OFS_T1CL  = 4'd4;
  localparam logic [3:0] OFS_T1CH  = 4'd5;
  localparam logic [3:0] OFS_T1LL  = 4'd6;
  localparam logic [3:0] OFS_T1LH  = 4'd7;
  localparam logic [3:0] OFS_T2CL  = 4'd8;
  localparam logic [3:0] OFS_T2CH  = 4'd9;
  localparam logic [3:0] OFS_SHIFT = 4'd10;
  localparam logic [3:0] OFS_ACR   = 4'd11;
  localparam logic [3:0] OFS_PCR   = 4'd12;
  localparam logic [3:0] OFS_IFR   = 4'd13;
  localparam logic [3:0] OFS_IER   = 4'd14;
  localparam logic [3:0] OFS_ORANH = 4'd15;

  localparam int BIT_CA1 = 1;
  localparam int BIT_CB1 = 4;
  localparam int BIT_T2  = 5;
  localparam int BIT_T1  = 6;

  typedef struct packed {
    logic wrOrb;
    logic wrOra;
    logic wrDdrb;
    logic wrDdra;
    logic wrT1LatLo;
    logic wrT1LatHi;
    logic wrT1Start;
    logic wrT2LatLo;
    logic wrT2Start;
    logic wrAcr;
    logic wrPcr;
    logic wrIfr;
    logic wrIer;
    logic clrCa;
    logic clrCb;
    logic clrT1;
    logic clrT2;
  } viaStrobes_t;
endpackage

// File: rtl/viaCtrl.sv
module viaCtrl
  import viaPkg::*;
(
  input  logic        cs,
  input  logic        we,
  input  logic [3:0]  regSel,
  output viaStrobes_t strb
);
  logic wrAcc;
  logic rdAcc;

  assign wrAcc = cs & we;
  assign rdAcc = cs & ~we;

  always_comb begin
    strb = '0;
    unique case (regSel)
      OFS_ORB: begin
        strb.wrOrb = wrAcc;
        strb.clrCb = cs;
      end
      OFS_ORA: begin
        strb.wrOra = wrAcc;
        strb.clrCa = cs;
      end
      OFS_DDRB: strb.wrDdrb = wrAcc;
      OFS_DDRA: strb.wrDdra = wrAcc;
      OFS_T1CL: begin
        strb.wrT1LatLo = wrAcc;
        strb.clrT1     = rdAcc;
      end
      OFS_T1CH: begin
        strb.wrT1Start = wrAcc;
        strb.clrT1     = wrAcc;
      end
      OFS_T1LL: strb.wrT1LatLo = wrAcc;
      OFS_T1LH: strb.wrT1LatHi = wrAcc;
      OFS_T2CL: begin
        strb.wrT2LatLo = wrAcc;
        strb.clrT2     = cs;
      end
      OFS_T2CH: begin
        strb.wrT2Start = wrAcc;
        strb.clrT2     = wrAcc;
      end
      OFS_SHIFT: ;
      OFS_ACR: strb.wrAcr = wrAcc;
      OFS_PCR: strb.wrPcr = wrAcc;
      OFS_IFR: strb.wrIfr = wrAcc;
      OFS_IER: strb.wrIer = wrAcc;
      OFS_ORANH: strb.wrOra = wrAcc;
      default: ;
    endcase
  end
endmodule

// File: rtl/viaDatapath.sv
module viaDatapath
  import viaPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  viaStrobes_t       strb,
  input  logic [3:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portBOe,
  input  logic              ca1,
  input  logic              cb1,
  output logic              irq
);
  localparam int TMR_W   = 2 * DATA_W;
  localparam int TOG_BIT = DATA_W - 1;
  localparam int N_EDGE  = 2;

  logic [DATA_W-1:0] oraQ, orbQ, ddraQ, ddrbQ, acrQ, pcrQ;
  logic [DATA_W-1:0] t1LatLoQ, t1LatHiQ, t2LatLoQ;
  logic [TMR_W-1:0]  t1CntQ, t2CntQ;
  logic              t1RunQ, t1ArmQ, t2RunQ, t2ArmQ, togQ;
  logic [FLAG_W-1:0] ifrQ, ierQ, flagSet, flagClr;
  logic              t1Under, t2Under, t1Event, t2Event, freeRun, togEn;
  logic              primedQ;
  logic [N_EDGE-1:0] lineIn, linePrevQ, edgePol, edgeHit;
  logic              anyPending;

  assign freeRun = acrQ[6];
  assign togEn   = acrQ[7];

  // data registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oraQ <= '0; orbQ <= '0; ddraQ <= '0; ddrbQ <= '0;
      acrQ <= '0; pcrQ <= '0;
      t1LatLoQ <= '0; t1LatHiQ <= '0; t2LatLoQ <= '0;
    end else begin
      if (strb.wrOra)  oraQ  <= wrData;
      if (strb.wrOrb)  orbQ  <= wrData;
      if (strb.wrDdra) ddraQ <= wrData;
      if (strb.wrDdrb) ddrbQ <= wrData;
      if (strb.wrAcr)  acrQ  <= wrData;
      if (strb.wrPcr)  pcrQ  <= wrData;
      if (strb.wrT1LatLo) t1LatLoQ <= wrData;
      if (strb.wrT1LatHi || strb.wrT1Start) t1LatHiQ <= wrData;
      if (strb.wrT2LatLo) t2LatLoQ <= wrData;
    end
  end

  // timer 1
  assign t1Under = t1RunQ && (t1CntQ == '0) && !strb.wrT1Start;
  assign t1Event = t1Under && (t1ArmQ || freeRun);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1CntQ <= '0; t1RunQ <= 1'b0; t1ArmQ <= 1'b0; togQ <= 1'b0;
    end else if (strb.wrT1Start) begin
      t1CntQ <= {wrData, t1LatLoQ};
      t1RunQ <= 1'b1;
      t1ArmQ <= 1'b1;
      togQ   <= 1'b0;
    end else if (t1RunQ) begin
      if (t1Under && freeRun) t1CntQ <= {t1LatHiQ, t1LatLoQ};
      else                    t1CntQ <= t1CntQ - 1'b1;
      if (t1Under && !freeRun) t1ArmQ <= 1'b0;
      if (t1Event) togQ <= ~togQ;
    end
  end

  // timer 2
  assign t2Under = t2RunQ && (t2CntQ == '0) && !strb.wrT2Start;
  assign t2Event = t2Under && t2ArmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t2CntQ <= '0; t2RunQ <= 1'b0; t2ArmQ <= 1'b0;
    end else if (strb.wrT2Start) begin
      t2CntQ <= {wrData, t2LatLoQ};
      t2RunQ <= 1'b1;
      t2ArmQ <= 1'b1;
    end else if (t2RunQ) begin
      t2CntQ <= t2CntQ - 1'b1;
      if (t2Under) t2ArmQ <= 1'b0;
    end
  end

  // edge detectors for the two interrupt inputs
  assign lineIn  = {cb1, ca1};
  assign edgePol = {pcrQ[4], pcrQ[0]};

  always_ff @(posedge clk) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  for (genvar g = 0; g < N_EDGE; g++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) linePrevQ[g] <= 1'b0;
      else       linePrevQ[g] <= lineIn[g];
    end
    assign edgeHit[g] = primedQ &&
      (edgePol[g] ? (lineIn[g] && !linePrevQ[g]) : (!lineIn[g] && linePrevQ[g]));
  end

  // interrupt flags and enables
  always_comb begin
    flagSet = '0;
    flagSet[BIT_T1]  = t1Event;
    flagSet[BIT_T2]  = t2Event;
    flagSet[BIT_CA1] = edgeHit[0];
    flagSet[BIT_CB1] = edgeHit[1];
    flagClr = strb.wrIfr ? wrData[FLAG_W-1:0] : '0;
    if (strb.clrT1) flagClr[BIT_T1] = 1'b1;
    if (strb.clrT2) flagClr[BIT_T2] = 1'b1;
    if (strb.clrCa) flagClr[BIT_CA1] = 1'b1;
    if (strb.clrCb) flagClr[BIT_CB1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifrQ <= '0;
      ierQ <= '0;
    end else begin
      ifrQ <= (ifrQ & ~flagClr) | flagSet;
      if (strb.wrIer) begin
        if (wrData[FLAG_W]) ierQ <= ierQ | wrData[FLAG_W-1:0];
        else                ierQ <= ierQ & ~wrData[FLAG_W-1:0];
      end
    end
  end

  assign anyPending = |(ifrQ & ierQ);
  assign irq        = anyPending;

  // pin outputs
  assign portAOut = oraQ & ddraQ;
  assign portAOe  = ddraQ;

  always_comb begin
    portBOut = orbQ & ddrbQ;
    portBOe  = ddrbQ;
    if (togEn) begin
      portBOut[TOG_BIT] = togQ;
      portBOe[TOG_BIT]  = 1'b1;
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    unique case (regSel)
      OFS_ORB:   rdData = (portBOut & portBOe) | (portBIn & ~portBOe);
      OFS_ORA,
      OFS_ORANH: rdData = (portAOut & portAOe) | (portAIn & ~portAOe);
      OFS_DDRB:  rdData = ddrbQ;
      OFS_DDRA:  rdData = ddraQ;
      OFS_T1CL:  rdData = t1CntQ[DATA_W-1:0];
      OFS_T1CH:  rdData = t1CntQ[TMR_W-1:DATA_W];
      OFS_T1LL:  rdData = t1LatLoQ;
      OFS_T1LH:  rdData = t1LatHiQ;
      OFS_T2CL:  rdData = t2CntQ[DATA_W-1:0];
      OFS_T2CH:  rdData = t2CntQ[TMR_W-1:DATA_W];
      OFS_SHIFT: rdData = '0;
      OFS_ACR:   rdData = acrQ;
      OFS_PCR:   rdData = pcrQ;
      OFS_IFR:   rdData = DATA_W'({anyPending, ifrQ});
      OFS_IER:   rdData = DATA_W'({1'b1, ierQ});
      default:   rdData = '0;
    endcase
  end

  // assertions
  assert_t1_start_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrT1Start |=> !ifrQ[BIT_T1]);

  assert_ier_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrIer && !wrData[FLAG_W]) |=> ((ierQ & $past(wrData[FLAG_W-1:0])) == '0));

  assert_latch_to_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrOra |=> (portAOut == ($past(wrData) & portAOe)));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ierQ != '0));

  assert_oneshot_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!freeRun && t1RunQ && !t1ArmQ && !strb.wrT1Start) |=> !(ifrQ[BIT_T1] && !$past(ifrQ[BIT_T1])));
endmodule

// File: rtl/viaCore.sv
module viaCore
  import viaPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [3:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portBOut,
  output logic [DATA_W-1:0] portBOe,
  input  logic              ca1,
  input  logic              cb1,
  output logic              irq
);
  viaStrobes_t strb;

  viaCtrl u_ctrl (
    .cs     (cs),
    .we     (we),
    .regSel (regSel),
    .strb   (strb)
  );

  viaDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regSel   (regSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .portAOut (portAOut),
    .portAOe  (portAOe),
    .portBOut (portBOut),
    .portBOe  (portBOe),
    .ca1      (ca1),
    .cb1      (cb1),
    .irq      (irq)
  );
endmodule

// File: tb/viaCore_tb.sv
`timescale 1ns/1ps
module viaCore_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [3:0] regSel = '0;
  logic [7:0] wrData = '0, rdData;
  logic [7:0] portAIn = '0, portBIn = '0;
  logic [7:0] portAOut, portAOe, portBOut, portBOe;
  logic       ca1 = 1'b0, cb1 = 1'b0, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  viaCore u_dut (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut), .portBOe(portBOe),
    .ca1(ca1), .cb1(cb1), .irq(irq)
  );

  function automatic logic [7:0] expPort(logic [7:0] latch, logic [7:0] dir, logic [7:0] pin);
    return (latch & dir) | (pin & ~dir);
  endfunction

  function automatic logic [6:0] expIer(logic [6:0] old, logic [7:0] wr);
    return wr[7] ? (old | wr[6:0]) : (old & ~wr[6:0]);
  endfunction

  task automatic checkEq(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; regSel = a; wrData = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; regSel = a;
    #1 d = rdData;
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [6:0] ierM;
    void'($urandom(32'd20240611));
    waitNeg(4);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      busRead(a[3:0], rd);
      checkEq("R1", "reset register", {8'h0, rd}, 16'h0);
    end
    busRead(4'd13, rd); checkEq("R1", "reset flags", {8'h0, rd}, 16'h0);
    busRead(4'd14, rd); checkEq("R1", "reset enables", {8'h0, rd}, 16'h0080);
    checkEq("R1", "reset pins", {portAOut | portAOe, portBOut | portBOe}, 16'h0);
    checkEq("R1", "reset irq", {15'h0, irq}, 16'h0);
    waitNeg(20);
    busRead(4'd13, rd); checkEq("R1", "timers idle", {8'h0, rd}, 16'h0);

    // R13 shift slot and control readback
    busWrite(4'd10, 8'h5A);
    busRead(4'd10, rd); checkEq("R13", "offset 10", {8'h0, rd}, 16'h0);
    busWrite(4'd11, 8'h3C);
    busRead(4'd11, rd); checkEq("R13", "ACR readback", {8'h0, rd}, 16'h003C);
    busWrite(4'd12, 8'hA6);
    busRead(4'd12, rd); checkEq("R13", "PCR readback", {8'h0, rd}, 16'h00A6);
    busWrite(4'd11, 8'h00);
    busWrite(4'd12, 8'h00);

    // R2 / R3 random port patterns
    for (int i = 0; i < 24; i++) begin
      logic [7:0] dA, lA, pA, dB, lB, pB;
      dA = 8'($urandom); lA = 8'($urandom); pA = 8'($urandom);
      dB = 8'($urandom); lB = 8'($urandom); pB = 8'($urandom);
      busWrite(4'd3, dA); busWrite(4'd1, lA);
      busWrite(4'd2, dB); busWrite(4'd0, lB);
      portAIn = pA; portBIn = pB;
      busRead(4'd1, rd); checkEq("R2", "port A read", {8'h0, rd}, {8'h0, expPort(lA, dA, pA)});
      busRead(4'd0, rd); checkEq("R2", "port B read", {8'h0, rd}, {8'h0, expPort(lB, dB, pB)});
      busRead(4'd15, rd); checkEq("R2", "port A alt read", {8'h0, rd}, {8'h0, expPort(lA, dA, pA)});
      checkEq("R3", "port A pins", {portAOut, portAOe}, {lA & dA, dA});
      checkEq("R3", "port B pins", {portBOut, portBOe}, {lB & dB, dB});
    end
    busWrite(4'd3, 8'h00); busWrite(4'd2, 8'h00);

    // R4 random enable writes
    ierM = '0;
    for (int i = 0; i < 20; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      ierM = expIer(ierM, w);
      busWrite(4'd14, w);
      busRead(4'd14, rd); checkEq("R4", "enable readback", {8'h0, rd}, {8'h0, 1'b1, ierM});
    end
    busWrite(4'd14, 8'h7F);
    busRead(4'd14, rd); checkEq("R4", "enables cleared", {8'h0, rd}, 16'h0080);

    // R7 / R8 timer 1 one-shot, N = 6
    busWrite(4'd14, 8'hC0);
    busWrite(4'd4, 8'd6);
    busWrite(4'd5, 8'd0);
    waitNeg(6); checkEq("R7", "t1 before underflow irq", {15'h0, irq}, 16'h0);
    waitNeg(1); checkEq("R7", "t1 underflow irq", {15'h0, irq}, 16'h1);
    busRead(4'd13, rd); checkEq("R5", "flag reg t1", {8'h0, rd}, 16'h00C0);
    busRead(4'd5, rd);  checkEq("R7", "t1 counter high after wrap", {8'h0, rd}, 16'h00FF);
    busRead(4'd13, rd); checkEq("R11", "read 5 keeps t1 flag", {8'h0, rd}, 16'h00C0);
    busRead(4'd4, rd);
    busRead(4'd13, rd); checkEq("R11", "read 4 clears t1 flag", {8'h0, rd}, 16'h0);
    checkEq("R6", "irq low after clear", {15'h0, irq}, 16'h0);
    waitNeg(40);
    busRead(4'd13, rd); checkEq("R8", "one-shot no second flag", {8'h0, rd}, 16'h0);

    // R8 / R9 free-run with toggle, N = 6
    busWrite(4'd11, 8'hC0);
    busWrite(4'd4, 8'd6);
    busWrite(4'd5, 8'd0);
    checkEq("R9", "toggle low after start", {14'h0, portBOut[7], portBOe[7]}, 16'h1);
    waitNeg(7);
    checkEq("R8", "free-run first flag", {15'h0, irq}, 16'h1);
    checkEq("R9", "toggle high after first", {15'h0, portBOut[7]}, 16'h1);
    busWrite(4'd13, 8'h40);
    waitNeg(4); checkEq("R5", "flag cleared by write", {15'h0, irq}, 16'h0);
    checkEq("R9", "toggle holds", {15'h0, portBOut[7]}, 16'h1);
    waitNeg(1); checkEq("R8", "free-run second flag", {15'h0, irq}, 16'h1);
    checkEq("R9", "toggle low after second", {15'h0, portBOut[7]}, 16'h0);
    busWrite(4'd11, 8'h00);
    busWrite(4'd5, 8'hFF);
    busRead(4'd13, rd); checkEq("R7", "high write clears flag", {8'h0, rd}, 16'h0);
    busRead(4'd5, rd);  checkEq("R7", "counter high after load", {8'h0, rd}, 16'h00FF);
    busWrite(4'd6, 8'h34); busWrite(4'd7, 8'h12);
    busRead(4'd6, rd); checkEq("R7", "latch low", {8'h0, rd}, 16'h0034);
    busRead(4'd7, rd); checkEq("R7", "latch high", {8'h0, rd}, 16'h0012);

    // R10 / R11 timer 2, N = 4
    busWrite(4'd14, 8'h7F);
    busWrite(4'd14, 8'hA0);
    busWrite(4'd8, 8'd4);
    busWrite(4'd9, 8'd0);
    waitNeg(4); checkEq("R10", "t2 before underflow", {15'h0, irq}, 16'h0);
    waitNeg(1); checkEq("R10", "t2 underflow", {15'h0, irq}, 16'h1);
    busRead(4'd9, rd);  checkEq("R10", "t2 high after wrap", {8'h0, rd}, 16'h00FF);
    busRead(4'd13, rd); checkEq("R11", "read 9 keeps t2 flag", {8'h0, rd}, 16'h00A0);
    busWrite(4'd8, 8'd4);
    busRead(4'd13, rd); checkEq("R11", "write 8 clears t2 flag", {8'h0, rd}, 16'h0);
    waitNeg(30);
    busRead(4'd13, rd); checkEq("R10", "t2 once per start", {8'h0, rd}, 16'h0);
    busWrite(4'd9, 8'd0);
    waitNeg(10);
    busRead(4'd13, rd); checkEq("R10", "t2 restarted flag", {8'h0, rd}, 16'h00A0);
    busRead(4'd8, rd);
    busRead(4'd13, rd); checkEq("R11", "read 8 clears t2 flag", {8'h0, rd}, 16'h0);

    // R12 edge inputs
    busWrite(4'd14, 8'h7F);
    busWrite(4'd14, 8'h92);
    busWrite(4'd12, 8'h01);
    @(negedge clk); ca1 = 1'b1;
    waitNeg(1);
    busRead(4'd13, rd); checkEq("R12", "CA1 rising", {8'h0, rd}, 16'h0082);
    busRead(4'd15, rd);
    busRead(4'd13, rd); checkEq("R11", "offset 15 keeps CA1", {8'h0, rd}, 16'h0082);
    busRead(4'd1, rd);
    busRead(4'd13, rd); checkEq("R11", "offset 1 clears CA1", {8'h0, rd}, 16'h0);
    @(negedge clk); ca1 = 1'b0;
    waitNeg(2);
    busRead(4'd13, rd); checkEq("R12", "CA1 wrong edge", {8'h0, rd}, 16'h0);
    @(negedge clk); cb1 = 1'b1;
    waitNeg(2);
    busRead(4'd13, rd); checkEq("R12", "CB1 wrong edge", {8'h0, rd}, 16'h0);
    @(negedge clk); cb1 = 1'b0;
    waitNeg(2);
    busRead(4'd13, rd); checkEq("R12", "CB1 falling", {8'h0, rd}, 16'h0090);
    checkEq("R6", "irq with CB1", {15'h0, irq}, 16'h1);
    busWrite(4'd0, 8'h00);
    busRead(4'd13, rd); checkEq("R11", "offset 0 clears CB1", {8'h0, rd}, 16'h0);
    busWrite(4'd12, 8'h10);
    @(negedge clk); cb1 = 1'b1;
    waitNeg(2);
    busRead(4'd13, rd); checkEq("R12", "CB1 rising", {8'h0, rd}, 16'h0090);
    busWrite(4'd13, 8'h10);
    busRead(4'd13, rd); checkEq("R5", "write clears CB1", {8'h0, rd}, 16'h0);

    // R5 / R6 pending but not enabled
    busWrite(4'd14, 8'h12);
    busWrite(4'd12, 8'h01);
    @(negedge clk); ca1 = 1'b1;
    waitNeg(2);
    busRead(4'd13, rd); checkEq("R5", "flag without enable", {8'h0, rd}, 16'h0002);
    checkEq("R6", "irq stays low", {15'h0, irq}, 16'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule